// File: doc/BRIEF.md
# Serial Bitwise CRC-5 Engine

This block forms a 5-bit cyclic redundancy check over a serial message, one bit per clock, with the generator x^5 + x^2 + 1 (binary 100101). The message bits arrive most significant first, each one qualified by a valid strobe. The running remainder appears on the output after every accepted bit.

Two equivalent datapaths are available through a mode input. The long-division datapath treats the message as a dividend. The caller appends five zero bits after the message, and the remainder is read once they have been consumed. The direct-feed datapath XORs each incoming bit into the feedback term, so it needs no padding and gives the same remainder as soon as the last message bit is taken.

A synchronous clear starts a new message. The remainder is neither reflected nor inverted on the way out. The mode input may be changed only while the engine is held cleared.

Top module: `crc5_serial`

## Requirements
- R1: While the asynchronous reset is asserted, and through the two clock cycles of its synchronous release, the remainder output is 0.
- R2: When `clr` is high at a clock edge, the remainder is 0 after that edge, even if `bit_vld` is also high.
- R3: When `bit_vld` is low and `clr` is low at an edge, the remainder keeps its value, whatever `bit_in` and `mode_sel` are.
- R4: Long-division mode (`mode_sel` = 0): at each accepted bit, the remainder is shifted left with `bit_in` entering bit 0. If the old bit 4 was 1, the result is XORed with 5'b00101; otherwise nothing is subtracted.
- R5: In long-division mode, starting from clear, the message 11011010 followed by 00000 gives the intermediate remainders 0x01, 0x03, 0x06, 0x0d, 0x1b, 0x13, 0x02, 0x04, 0x08, 0x10, 0x05, 0x0a, 0x14, with a final value of 0x14.
- R6: In long-division mode, after each of the first five accepted bits following a clear, the remainder equals the leading message bits taken so far, right-aligned.
- R7: Direct-feed mode (`mode_sel` = 1): at each accepted bit, the feedback is old bit 4 XOR `bit_in`. The next remainder is the old remainder shifted left with 0 into bit 0, XORed with 5'b00101 when the feedback is 1.
- R8: For any message, the direct-feed remainder after the message alone equals the long-division remainder after the message plus five zero bits. For 11011010 both are 0x14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of the remainder, starts a new message |
| bit_vld | input | 1 | Qualifies `bit_in` for the current cycle |
| bit_in | input | 1 | Serial message bit, most significant first |
| mode_sel | input | 1 | 0 selects long division, 1 selects direct feed |
| crc_out | output | 5 | Running remainder |

## Verification
On every cycle the assertions check the clear, the hold when no bit is offered, the no-subtract shift of long division, and the direct-feed bit-0 feedback rule. Only the bench's scenarios can show that whole messages reach the right remainder. These scenarios cover the worked example step by step, the load-only first five steps, and the match between the padded long-division result and the unpadded direct-feed result over several bit patterns.

// File: rtl/crc5_pkg.sv
package crc5_pkg;
  parameter int unsigned CRC_W = 5;
  // generator without its leading x^5 term: x^2 + 1
  parameter logic [CRC_W-1:0] CRC_POLY = 5'b00101;

  typedef enum logic {
    MODE_DIV  = 1'b0,
    MODE_FEED = 1'b1
  } crc_mode_e;
endpackage

// File: rtl/crc5_rst_sync.sv
module crc5_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/crc5_next.sv
module crc5_next
  import crc5_pkg::*;
#(
  parameter int unsigned W = CRC_W,
  parameter logic [W-1:0] POLY = CRC_POLY
) (
  input  logic [W-1:0] cur,
  input  logic         din,
  input  crc_mode_e    mode,
  output logic [W-1:0] nxt
);
  logic         fb;
  logic [W-1:0] shifted;
  logic [W-1:0] sub_mask;

  always_comb begin
    if (mode == MODE_DIV) begin
      // trial = {cur, din}; its top bit decides the subtraction
      fb      = cur[W-1];
      shifted = {cur[W-2:0], din};
    end else begin
      fb      = cur[W-1] ^ din;
      shifted = {cur[W-2:0], 1'b0};
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign sub_mask[i] = POLY[i] & fb;
  end

  assign nxt = shifted ^ sub_mask;
endmodule

// File: rtl/crc5_state_reg.sv
module crc5_state_reg #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (en)  q <= d;
  end
endmodule

// File: rtl/crc5_serial.sv
module crc5_serial
  import crc5_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             mode_sel,
  output logic [CRC_W-1:0] crc_out
);
  logic             srst_n;
  logic [CRC_W-1:0] rem_q;
  logic [CRC_W-1:0] rem_d;
  crc_mode_e        mode;

  assign mode = crc_mode_e'(mode_sel);

  crc5_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  crc5_next #(.W(CRC_W), .POLY(CRC_POLY)) u_next (
    .cur  (rem_q),
    .din  (bit_in),
    .mode (mode),
    .nxt  (rem_d)
  );

  crc5_state_reg #(.W(CRC_W)) u_rem (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (clr),
    .en    (bit_vld),
    .d     (rem_d),
    .q     (rem_q)
  );

  assign crc_out = rem_q;

  // R2: clear wins over a valid bit
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!srst_n)
    clr |=> (crc_out == '0));

  // R3: no accepted bit, no change
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!srst_n)
    (!clr && !bit_vld) |=> $stable(crc_out));

  // R4: long division with a clear top bit is a pure shift-in
  a_r4_div_no_sub: assert property (@(posedge clk) disable iff (!srst_n)
    (!clr && bit_vld && !mode_sel && !crc_out[CRC_W-1])
      |=> (crc_out == {$past(crc_out[CRC_W-2:0]), $past(bit_in)}));

  // R7: in direct feed, bit 0 carries the feedback term
  a_r7_feed_lsb: assert property (@(posedge clk) disable iff (!srst_n)
    (!clr && bit_vld && mode_sel)
      |=> (crc_out[0] == ($past(crc_out[CRC_W-1]) ^ $past(bit_in))));
endmodule

// File: tb/crc5_serial_tb_top.sv
module crc5_serial_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       clr = 1'b0;
  logic       bit_vld = 1'b0;
  logic       bit_in = 1'b0;
  logic       mode_sel = 1'b0;
  logic [4:0] crc_out;

  int n_tests = 0;
  int n_fail  = 0;

  logic [4:0] exp_q[$];
  string      tag_q[$];
  logic [4:0] model;

  always #2.5 clk = ~clk;

  crc5_serial dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_vld(bit_vld),
    .bit_in(bit_in), .mode_sel(mode_sel), .crc_out(crc_out)
  );

  task automatic chk(input logic [4:0] act, input logic [4:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // reference as polynomial division over the 6-bit trial value
  function automatic logic [4:0] ref_div(input logic [4:0] s, input logic b);
    logic [5:0] t;
    t = {s, b};
    if (t[5]) t = t ^ 6'b100101;
    return t[4:0];
  endfunction

  function automatic logic [4:0] ref_feed(input logic [4:0] s, input logic b);
    logic [4:0] r;
    r = {s[3:0], 1'b0};
    if (s[4] ^ b) r = r ^ 5'b00101;
    return r;
  endfunction

  // monitor: pops one expected item per accepted bit
  initial begin
    forever begin
      logic took;
      @(posedge clk);
      took = bit_vld && !clr && rst_n;
      #1;
      if (took && exp_q.size() > 0) chk(crc_out, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic send(input logic b, input string tag);
    @(negedge clk);
    bit_vld = 1'b1;
    bit_in  = b;
    model   = mode_sel ? ref_feed(model, b) : ref_div(model, b);
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  task automatic send_exp(input logic b, input logic [4:0] e, input string tag);
    @(negedge clk);
    bit_vld = 1'b1;
    bit_in  = b;
    model   = e;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic clear(input logic m, input logic with_vld);
    @(negedge clk);
    clr      = 1'b1;
    bit_vld  = with_vld;
    bit_in   = 1'b1;
    mode_sel = m;
    model    = '0;
    @(negedge clk);
    clr     = 1'b0;
    bit_vld = 1'b0;
    chk(crc_out, 5'h00, "R2 clear");
  endtask

  task automatic run_msg(input logic [15:0] msg, input int len, input logic m,
                         output logic [4:0] res);
    clear(m, 1'b0);
    for (int i = len - 1; i >= 0; i--) send(msg[i], m ? "R7 feed step" : "R4 div step");
    if (!m) for (int i = 0; i < 5; i++) send(1'b0, "R4 div pad");
    idle();
    @(negedge clk);
    res = crc_out;
  endtask

  logic [4:0] ex_vals [13] = '{5'h01, 5'h03, 5'h06, 5'h0d, 5'h1b, 5'h13, 5'h02,
                              5'h04, 5'h08, 5'h10, 5'h05, 5'h0a, 5'h14};
  logic [12:0] ex_bits = 13'b1101101000000;
  logic        done = 1'b0;

  initial begin
    logic [4:0] r_div;
    logic [4:0] r_feed;
    logic [4:0] held;
    logic [15:0] pats [4] = '{16'hA5F3, 16'hFFFF, 16'h5555, 16'h8001};
    int          lens [4] = '{16, 11, 16, 9};

    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(crc_out, 5'h00, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(crc_out, 5'h00, "R1 release");
    repeat (3) @(negedge clk);

    // worked example, long division with padding
    clear(1'b0, 1'b0);
    for (int i = 0; i < 13; i++)
      send_exp(ex_bits[12-i], ex_vals[i], (i < 5) ? "R6 load-only" : "R5 example");
    idle();
    @(negedge clk);
    chk(crc_out, 5'h14, "R5 final");

    // same message, direct feed, no padding
    clear(1'b1, 1'b0);
    for (int i = 0; i < 8; i++) send(ex_bits[12-i], "R7 feed step");
    idle();
    @(negedge clk);
    chk(crc_out, 5'h14, "R8 example");

    // hold: idle cycles with wiggling data and mode mid-message
    clear(1'b0, 1'b0);
    send(1'b1, "R4 div step");
    send(1'b1, "R4 div step");
    idle();
    @(negedge clk);
    held = crc_out;
    for (int i = 0; i < 4; i++) begin
      bit_in   = i[0];
      mode_sel = ~i[0];
      @(negedge clk);
      chk(crc_out, held, "R3 hold");
    end
    mode_sel = 1'b0;

    // clear together with a valid bit
    send(1'b1, "R4 div step");
    clear(1'b0, 1'b1);

    // several patterns, both modes must agree
    for (int p = 0; p < 4; p++) begin
      run_msg(pats[p], lens[p], 1'b0, r_div);
      run_msg(pats[p], lens[p], 1'b1, r_feed);
      chk(r_feed, r_div, "R8 modes agree");
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule